// File: doc/BRIEF.md
# Dual-Mode Preset Counter Timer

This block is a down-counter loaded from two preset bytes, an upper one and a lower one. It runs in one of two modes. As a timer it produces a continuous square wave whose half-period is the preset count, measured in count-enable pulses. As an event counter it counts enable pulses after a start command, signals when it reaches terminal count, and keeps counting until a stop command arrives. The enable pulse comes from a timing source chosen outside the block. Routing the wave output to a pin is also done elsewhere.

A controller writes the two preset bytes and selects the mode with a single input. It drives the block with one-cycle start and stop strobes. It reads the running count through a capture strobe, which freezes both bytes together so that the value read is always consistent. A preset of zero stands for 65536 pulses.

Top module: `preset_ctr_timer`

## Requirements
- R1: After reset the block is idle: wave output high, ready flag low, captured count 0. Enable pulses before the first start command change none of these.
- R2: Timer mode (`timer_mode_i`=1): a start strobe sets the wave high and loads the preset {upper,lower}. The wave then toggles after every N enable pulses, where N is the preset.
- R3: Timer mode: the ready flag sets when the wave goes from low to high, which is once per full period. It stays set until cleared.
- R4: Timer mode: a preset written during a half-period does not change that half-period. It takes effect from the next reload.
- R5: Timer mode: a stop strobe clears the ready flag and leaves the wave and the count running. A start strobe abandons the current cycle, sets the wave high and reloads the count from the presets.
- R6: Counter mode (`timer_mode_i`=0): a start strobe loads the preset and sets the wave high. The wave stays high until the Nth enable pulse, when it goes low and the ready flag sets.
- R7: Counter mode: counting continues past terminal count. The count wraps from 0 to 0xFFFF and keeps decrementing, and the wave stays low.
- R8: Counter mode: a stop strobe returns the wave high, clears the ready flag and halts the count at its current value.
- R9: A preset of 0 behaves as 65536 enable pulses.
- R10: A capture strobe copies the whole 16-bit count at once into the read value (`cnt_hi_o` = bits 15:8, `cnt_lo_o` = bits 7:0). The read value does not change between captures.
- R11: When start and stop strobes arrive in the same cycle, the start takes effect and the stop is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Count-enable pulse from the selected timing source |
| wr_hi_i | input | 1 | Write strobe for the upper preset byte |
| wr_lo_i | input | 1 | Write strobe for the lower preset byte |
| wr_data_i | input | 8 | Preset byte data |
| timer_mode_i | input | 1 | 1 = square-wave timer, 0 = event counter |
| start_i | input | 1 | Start command strobe |
| stop_i | input | 1 | Stop command strobe |
| cap_i | input | 1 | Capture strobe for the readable count |
| wave_o | output | 1 | Square wave (timer) or terminal-count output (counter) |
| ready_o | output | 1 | Counter-ready flag |
| cnt_hi_o | output | 8 | Captured count, upper byte |
| cnt_lo_o | output | 8 | Captured count, lower byte |

## Verification
Every result of the block is registered. A strobe or enable pulse presented in one cycle changes the wave, the ready flag, the count or the captured value at the next rising edge, so every result is due exactly one cycle after its stimulus. The bench drives inputs at the falling edge. Each stimulus task returns at the falling edge that follows the rising edge where the result lands, and pushes its expected values at that moment. The monitor then compares them a moment later, while every output is steady between edges. Counts are read only through a capture strobe issued with no enable pulse active, so the captured value is fixed before it is compared.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
   typedef enum logic {
      MODE_COUNTER = 1'b0,
      MODE_TIMER   = 1'b1
   } ctr_mode_e;
endpackage

// File: rtl/ctr_preset_regs.sv
module ctr_preset_regs #(
   parameter int BYTE_W = 8,
   localparam int CNT_W = 2 * BYTE_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_hi_i,
   input  logic              wr_lo_i,
   input  logic [BYTE_W-1:0] wr_data_i,
   output logic [CNT_W-1:0]  preset_o
);
   logic [BYTE_W-1:0] hi_q, lo_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         hi_q <= '0;
         lo_q <= '0;
      end else begin
         if (wr_hi_i) hi_q <= wr_data_i;
         if (wr_lo_i) lo_q <= wr_data_i;
      end
   end

   assign preset_o = {hi_q, lo_q};
endmodule

// File: rtl/ctr_core.sv
module ctr_core
   import ctr_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  logic             mode_i,
   input  logic             start_i,
   input  logic             stop_i,
   input  logic [CNT_W-1:0] preset_i,
   output logic             wave_o,
   output logic             ready_o,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

   ctr_mode_e        mode;
   logic [CNT_W-1:0] cnt_q;
   logic             wave_q, ready_q, run_q;
   logic             at_last, halt_req, adv;

   assign mode     = ctr_mode_e'(mode_i);
   assign at_last  = (cnt_q == LAST);
   assign halt_req = stop_i && (mode == MODE_COUNTER);
   assign adv      = run_q && tick_i && !halt_req;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q   <= '0;
         wave_q  <= 1'b1;
         ready_q <= 1'b0;
         run_q   <= 1'b0;
      end else if (start_i) begin
         cnt_q  <= preset_i;
         wave_q <= 1'b1;
         run_q  <= 1'b1;
      end else begin
         if (stop_i) begin
            ready_q <= 1'b0;
            if (halt_req) begin
               run_q  <= 1'b0;
               wave_q <= 1'b1;
            end
         end
         if (adv) begin
            if (mode == MODE_TIMER) begin
               if (at_last) begin
                  cnt_q  <= preset_i;
                  wave_q <= ~wave_q;
                  if (!wave_q && !stop_i) ready_q <= 1'b1;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end else begin
               cnt_q <= cnt_q - 1'b1;
               if (at_last) begin
                  wave_q  <= 1'b0;
                  ready_q <= 1'b1;
               end
            end
         end
      end
   end

   assign wave_o  = wave_q;
   assign ready_o = ready_q;
   assign cnt_o   = cnt_q;

   // R1
   idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_q |-> wave_q);
   // R6
   start_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |=> (wave_q && cnt_q == $past(preset_i)));
   // R5
   timer_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stop_i && !start_i && mode_i) |=> !ready_q);
   // R8
   ctr_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stop_i && !start_i && !mode_i) |=> (wave_q && !ready_q && !run_q));
   // R7
   ctr_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_q && tick_i && !mode_i && !start_i && !stop_i) |=>
         (cnt_q == $past(cnt_q) - 1'b1));
   // R3
   ready_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(ready_q) && $past(mode_i) && !$past(start_i)) |-> $rose(wave_q));
endmodule

// File: rtl/ctr_snapshot.sv
module ctr_snapshot #(
   parameter int CNT_W       = 16,
   parameter bit COHERENT_RD = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             cap_i,
   input  logic [CNT_W-1:0] cnt_i,
   output logic [CNT_W-1:0] snap_o
);
   if (COHERENT_RD) begin : g_coh
      logic [CNT_W-1:0] snap_q;
      always_ff @(posedge clk_i) begin
         if (!rst_ni)    snap_q <= '0;
         else if (cap_i) snap_q <= cnt_i;
      end
      assign snap_o = snap_q;

      // R10
      snap_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         cap_i |=> (snap_o == $past(cnt_i)));
      // R10
      snap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (!cap_i && !$past(!rst_ni)) |=> $stable(snap_o));
   end else begin : g_live
      assign snap_o = cnt_i;
   end
endmodule

// File: rtl/preset_ctr_timer.sv
module preset_ctr_timer #(
   parameter int BYTE_W      = 8,
   parameter int CNT_W       = 16,
   parameter bit COHERENT_RD = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic              wr_hi_i,
   input  logic              wr_lo_i,
   input  logic [BYTE_W-1:0] wr_data_i,
   input  logic              timer_mode_i,
   input  logic              start_i,
   input  logic              stop_i,
   input  logic              cap_i,
   output logic              wave_o,
   output logic              ready_o,
   output logic [BYTE_W-1:0] cnt_hi_o,
   output logic [BYTE_W-1:0] cnt_lo_o
);
   if (CNT_W != 2 * BYTE_W) begin : g_bad_width
      $error("CNT_W must equal two preset bytes");
   end
   if (BYTE_W < 2) begin : g_bad_byte
      $error("BYTE_W too small");
   end

   logic [CNT_W-1:0] preset, cnt, snap;

   ctr_preset_regs #(.BYTE_W(BYTE_W)) u_regs (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .wr_hi_i(wr_hi_i), .wr_lo_i(wr_lo_i), .wr_data_i(wr_data_i),
      .preset_o(preset)
   );

   ctr_core #(.CNT_W(CNT_W)) u_core (
      .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
      .mode_i(timer_mode_i), .start_i(start_i), .stop_i(stop_i),
      .preset_i(preset), .wave_o(wave_o), .ready_o(ready_o), .cnt_o(cnt)
   );

   ctr_snapshot #(.CNT_W(CNT_W), .COHERENT_RD(COHERENT_RD)) u_snap (
      .clk_i(clk_i), .rst_ni(rst_ni), .cap_i(cap_i),
      .cnt_i(cnt), .snap_o(snap)
   );

   assign cnt_hi_o = snap[CNT_W-1 -: BYTE_W];
   assign cnt_lo_o = snap[BYTE_W-1:0];
endmodule

// File: tb/preset_ctr_timer_bench.sv
`timescale 1ns/1ps
module preset_ctr_timer_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0, wr_hi = 1'b0, wr_lo = 1'b0;
   logic [7:0] wr_data = '0;
   logic       mode = 1'b1, start = 1'b0, stop = 1'b0, cap = 1'b0;
   logic       wave, ready;
   logic [7:0] cnt_hi, cnt_lo;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   typedef struct {
      string req;
      int    sel;   // 0 wave, 1 ready, 2 captured count
      int    exp;
   } exp_t;
   exp_t q[$];

   always #4 clk = ~clk;

   preset_ctr_timer u_preset_ctr_timer (
      .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
      .wr_hi_i(wr_hi), .wr_lo_i(wr_lo), .wr_data_i(wr_data),
      .timer_mode_i(mode), .start_i(start), .stop_i(stop), .cap_i(cap),
      .wave_o(wave), .ready_o(ready), .cnt_hi_o(cnt_hi), .cnt_lo_o(cnt_lo)
   );

   task automatic expect_v(string req, int sel, int exp);
      exp_t e;
      e.req = req; e.sel = sel; e.exp = exp;
      q.push_back(e);
   endtask

   task automatic ticks(int n);
      if (n > 0) begin
         tick = 1'b1;
         repeat (n) @(negedge clk);
         tick = 1'b0;
      end
   endtask

   task automatic do_start();
      start = 1'b1; @(negedge clk); start = 1'b0;
   endtask

   task automatic do_stop();
      stop = 1'b1; @(negedge clk); stop = 1'b0;
   endtask

   task automatic do_cap();
      cap = 1'b1; @(negedge clk); cap = 1'b0;
   endtask

   task automatic set_preset(int v);
      wr_data = 8'(v >> 8); wr_hi = 1'b1; @(negedge clk); wr_hi = 1'b0;
      wr_data = 8'(v);      wr_lo = 1'b1; @(negedge clk); wr_lo = 1'b0;
   endtask

   // monitor: pops expected items and compares while outputs are steady
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (q.size() > 0) begin
            exp_t e;
            int act;
            e = q.pop_front();
            case (e.sel)
               0:       act = int'(wave);
               1:       act = int'(ready);
               default: act = int'({cnt_hi, cnt_lo});
            endcase
            checks++;
            if (act != e.exp) begin
               errors++;
               $display("FAIL %s sel=%0d actual=0x%0h expected=0x%0h",
                        e.req, e.sel, act, e.exp);
            end
         end
      end
   end

   initial begin
      #(150000 * 8);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state and pulses before start ignored
      ticks(4);
      do_cap();
      expect_v("R1", 0, 1); expect_v("R1", 1, 0); expect_v("R1", 2, 0);

      // R2 timer half-period of 3
      mode = 1'b1;
      set_preset(3);
      do_start();
      expect_v("R2", 0, 1);
      ticks(2); expect_v("R2", 0, 1);
      ticks(1); expect_v("R2", 0, 0); expect_v("R3", 1, 0);
      ticks(3); expect_v("R2", 0, 1); expect_v("R3", 1, 1);

      // R4 preset change mid half-period
      ticks(1);
      set_preset(5);
      ticks(2); expect_v("R4", 0, 0);
      ticks(4); expect_v("R4", 0, 0);
      ticks(1); expect_v("R4", 0, 1); expect_v("R3", 1, 1);

      // R5 stop clears ready only, start reloads
      do_stop();
      expect_v("R5", 1, 0); expect_v("R5", 0, 1);
      ticks(5); expect_v("R5", 0, 0); expect_v("R5", 1, 0);
      ticks(2);
      do_start();
      do_cap();
      expect_v("R5", 0, 1); expect_v("R5", 2, 5);

      // R6 counter mode terminal count
      mode = 1'b0;
      set_preset(4);
      do_stop();
      do_start();
      ticks(3); expect_v("R6", 0, 1); expect_v("R6", 1, 0);
      ticks(1); expect_v("R6", 0, 0); expect_v("R6", 1, 1);
      // R7 counting past terminal count
      ticks(2);
      do_cap();
      expect_v("R7", 2, 'hFFFE); expect_v("R7", 0, 0);
      // R8 stop returns high, clears ready, halts count
      do_stop();
      expect_v("R8", 0, 1); expect_v("R8", 1, 0);
      ticks(3);
      do_cap();
      expect_v("R8", 2, 'hFFFE);

      // R11 start and stop together: start wins
      start = 1'b1; stop = 1'b1; @(negedge clk); start = 1'b0; stop = 1'b0;
      ticks(4); expect_v("R11", 0, 0); expect_v("R11", 1, 1);

      // R10 coherent capture
      set_preset('h0123);
      do_stop();
      do_start();
      ticks('h10);
      do_cap();
      expect_v("R10", 2, 'h0113);
      ticks(5);
      expect_v("R10", 2, 'h0113);
      do_cap();
      expect_v("R10", 2, 'h010E);

      // R9 zero preset is 65536
      set_preset(0);
      do_stop();
      do_start();
      ticks(65535); expect_v("R9", 1, 0); expect_v("R9", 0, 1);
      ticks(1);     expect_v("R9", 1, 1); expect_v("R9", 0, 0);

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule